// File: doc/BRIEF.md
# Calendar Clock with Hundredths

This block keeps time of day and date for a larger chip. A single-cycle enable pulse arrives at 100 Hz, produced elsewhere from a slower reference. Each pulse advances a chain of packed-BCD counters: hundredths of seconds, seconds, minutes, hours, weekday, day of month, month and two-digit year. The date follows the real length of each month, and February gets a 29th day in years divisible by four.

Hours can be kept in 24-hour form or in 12-hour form with a PM flag. Changing the format converts the stored hour on the spot. A host port writes any one field per cycle and reads any field combinationally. A halt input freezes all counting and keeps the stored state.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the fields read hundredths 00, seconds 00, minutes 00, hours 00, weekday 1, date 01, month 01, year 00, and the format is 24-hour.
- R2: Each counting pulse advances hundredths in BCD from 00 to 99. Going from 99 to 00 advances seconds. Seconds and minutes count 00 to 59, and each wrap advances the next field.
- R3: In 24-hour format the hour counts 00 to 23. The step from 23 to 00 advances the date and the weekday. The weekday counts 1 to 7 and wraps to 1.
- R4: The date wraps to 01 after day 30 in months 04, 06, 09 and 11, and after day 31 in the other months except 02. Each wrap advances the month. Month 12 wraps to 01 and advances the year, which counts 00 to 99 and wraps to 00.
- R5: In month 02 the date wraps after day 29 when the BCD year is divisible by 4 (00 counts as a leap year). In other years it wraps after day 28.
- R6: In 12-hour format the hour runs 12, 01, 02 … 11. The PM flag toggles on the step from 11 to 12. Going from 11 PM to 12 AM advances the date.
- R7: Writing field 8 with a format bit different from the current one converts the hour. 00→12 AM, 01–11→same AM, 12→12 PM, 13–23→01–11 PM, and the reverse mapping applies when going back to 24-hour.
- R8: While halt is high, counting pulses change no field.
- R9: A host write takes priority over a counting pulse in the same cycle. The written field takes the written value and no other field advances.
- R10: Field selects are 0 hundredths, 1 seconds, 2 minutes, 3 hours, 4 weekday, 5 date, 6 month, 7 year, 8 format (bit 0 = 1 for 12-hour). The hours byte has BCD hour in bits 5:0 and the PM flag in bit 6. Bit 6 reads 0 in 24-hour format. The read port returns the selected field in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | 100 Hz single-cycle count enable |
| halt | input | 1 | Freeze counting while high |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 4 | Field select for writes |
| wr_data | input | 8 | Write data, packed BCD |
| rd_sel | input | 4 | Field select for reads |
| rd_data | output | 8 | Selected field value |

## Verification
Every counting pulse and every host write, including a format change, shows its result on the read port at the first rising edge after the cycle it was applied in. The read port adds no cycle of its own. The bench drives each stimulus on a falling edge for exactly one cycle. It then reads each field one nanosecond after the next falling edge, so it samples after that single update and before any other edge. Carry chains across all fields resolve in that same cycle, so a full year rollover is checked after one pulse.

// File: rtl/rtc_calendar.sv
module rtc_calendar (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       halt,
  input  logic       wr_en,
  input  logic [3:0] wr_sel,
  input  logic [7:0] wr_data,
  input  logic [3:0] rd_sel,
  output logic [7:0] rd_data
);

  function automatic logic [7:0] inc8(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [6:0] bcd2bin(input logic [7:0] v);
    return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
  endfunction

  function automatic logic [7:0] bin2bcd(input logic [6:0] b);
    return {4'(b / 7'd10), 4'(b % 7'd10)};
  endfunction

  logic [7:0] hs_q, sec_q, min_q, date_q, month_q, year_q;
  logic [5:0] hr_q;
  logic [2:0] wd_q;
  logic       pm_q, mode_q;

  logic adv, c_s, c_m, c_h, c_d, c_mo, c_y;
  logic leap;
  logic [4:0] lsum;
  logic [7:0] last_day;
  logic [5:0] hr_inc;
  logic [6:0] hbin;
  logic [5:0] hr12, hr24;
  logic       pm12;

  assign adv  = tick & ~halt & ~wr_en;
  assign c_s  = adv & (hs_q == 8'h99);
  assign c_m  = c_s & (sec_q == 8'h59);
  assign c_h  = c_m & (min_q == 8'h59);
  assign c_d  = c_h & (mode_q ? (hr_q == 6'h11 && pm_q) : (hr_q == 6'h23));
  assign c_mo = c_d & (date_q == last_day);
  assign c_y  = c_mo & (month_q == 8'h12);

  assign lsum = {1'b0, year_q[3:0]} + {3'b0, year_q[4], 1'b0};
  assign leap = (lsum[1:0] == 2'b00);

  always_comb begin
    case (month_q)
      8'h02:                      last_day = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  end

  assign hr_inc = 6'(inc8({2'b00, hr_q}));
  assign hbin   = bcd2bin({2'b00, hr_q});

  always_comb begin
    if (hbin == 7'd0) begin
      hr12 = 6'h12; pm12 = 1'b0;
    end else if (hbin < 7'd12) begin
      hr12 = hr_q;  pm12 = 1'b0;
    end else if (hbin == 7'd12) begin
      hr12 = 6'h12; pm12 = 1'b1;
    end else begin
      hr12 = 6'(bin2bcd(hbin - 7'd12)); pm12 = 1'b1;
    end
    if (hbin == 7'd12) hr24 = pm_q ? 6'h12 : 6'h00;
    else if (pm_q)     hr24 = 6'(bin2bcd(hbin + 7'd12));
    else               hr24 = hr_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_q    <= 8'h00;
      sec_q   <= 8'h00;
      min_q   <= 8'h00;
      hr_q    <= 6'h00;
      pm_q    <= 1'b0;
      wd_q    <= 3'd1;
      date_q  <= 8'h01;
      month_q <= 8'h01;
      year_q  <= 8'h00;
      mode_q  <= 1'b0;
    end else if (wr_en) begin
      case (wr_sel)
        4'd0: hs_q    <= wr_data;
        4'd1: sec_q   <= wr_data;
        4'd2: min_q   <= wr_data;
        4'd3: begin hr_q <= wr_data[5:0]; pm_q <= wr_data[6]; end
        4'd4: wd_q    <= wr_data[2:0];
        4'd5: date_q  <= wr_data;
        4'd6: month_q <= wr_data;
        4'd7: year_q  <= wr_data;
        4'd8: begin
          mode_q <= wr_data[0];
          if (wr_data[0] && !mode_q) begin
            hr_q <= hr12; pm_q <= pm12;
          end else if (!wr_data[0] && mode_q) begin
            hr_q <= hr24;
          end
        end
        default: ;
      endcase
    end else if (adv) begin
      hs_q <= (hs_q == 8'h99) ? 8'h00 : inc8(hs_q);
      if (c_s) sec_q <= (sec_q == 8'h59) ? 8'h00 : inc8(sec_q);
      if (c_m) min_q <= (min_q == 8'h59) ? 8'h00 : inc8(min_q);
      if (c_h) begin
        if (mode_q) begin
          hr_q <= (hr_q == 6'h12) ? 6'h01 : hr_inc;
          if (hr_q == 6'h11) pm_q <= ~pm_q;
        end else begin
          hr_q <= (hr_q == 6'h23) ? 6'h00 : hr_inc;
        end
      end
      if (c_d) begin
        wd_q   <= (wd_q == 3'd7) ? 3'd1 : wd_q + 3'd1;
        date_q <= (date_q == last_day) ? 8'h01 : inc8(date_q);
      end
      if (c_mo) month_q <= (month_q == 8'h12) ? 8'h01 : inc8(month_q);
      if (c_y)  year_q  <= (year_q == 8'h99) ? 8'h00 : inc8(year_q);
    end
  end

  always_comb begin
    case (rd_sel)
      4'd0:    rd_data = hs_q;
      4'd1:    rd_data = sec_q;
      4'd2:    rd_data = min_q;
      4'd3:    rd_data = {1'b0, mode_q & pm_q, hr_q};
      4'd4:    rd_data = {5'b0, wd_q};
      4'd5:    rd_data = date_q;
      4'd6:    rd_data = month_q;
      4'd7:    rd_data = year_q;
      4'd8:    rd_data = {7'b0, mode_q};
      default: rd_data = 8'h00;
    endcase
  end

  // R2
  hs_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_s |=> (hs_q == 8'h00));

  // R3
  midnight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_d && !mode_q) |=> (hr_q == 6'h00 && date_q != $past(date_q)));

  // R4
  date_roll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_mo |=> (date_q == 8'h01));

  // R6
  pm_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_h && mode_q && hr_q == 6'h11) |=> (pm_q != $past(pm_q) && hr_q == 6'h12));

  // R8
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !wr_en) |=> ($stable(hs_q) && $stable(sec_q) && $stable(date_q)));

  // R9
  wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 4'd0) |=> (hs_q == $past(wr_data) && $stable(sec_q)));

endmodule

// File: tb/rtc_calendar_test.sv
`timescale 1ns/1ps
module rtc_calendar_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, halt = 1'b0, wr_en = 1'b0;
  logic [3:0] wr_sel = 4'd0, rd_sel = 4'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  rtc_calendar uut (.clk(clk), .rst_n(rst_n), .tick(tick), .halt(halt),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data));

  always #2 clk = ~clk;

  task automatic chk(input logic [3:0] sel, input logic [7:0] exp, input string req);
    rd_sel = sel;
    #1;
    checks++;
    if (rd_data !== exp) begin
      fails++;
      $display("FAIL %s field %0d: got %h expected %h", req, sel, rd_data, exp);
    end
  endtask

  task automatic wr(input logic [3:0] sel, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic set_eod(input logic [7:0] hr);
    wr(4'd0, 8'h99); wr(4'd1, 8'h59); wr(4'd2, 8'h59); wr(4'd3, hr);
  endtask

  task automatic t_reset();
    chk(0, 8'h00, "R1"); chk(1, 8'h00, "R1"); chk(2, 8'h00, "R1");
    chk(3, 8'h00, "R1"); chk(4, 8'h01, "R1"); chk(5, 8'h01, "R1");
    chk(6, 8'h01, "R1"); chk(7, 8'h00, "R1"); chk(8, 8'h00, "R10");
  endtask

  task automatic t_count();
    wr(4'd0, 8'h08); pulse(); chk(0, 8'h09, "R2");
    pulse(); chk(0, 8'h10, "R2");
    wr(4'd0, 8'h98); wr(4'd1, 8'h20); pulse(); chk(0, 8'h99, "R2");
    pulse(); chk(0, 8'h00, "R2"); chk(1, 8'h21, "R2");
    wr(4'd0, 8'h99); wr(4'd1, 8'h59); wr(4'd2, 8'h14); pulse();
    chk(1, 8'h00, "R2"); chk(2, 8'h15, "R2");
  endtask

  task automatic t_year_roll();
    wr(4'd4, 8'h07); wr(4'd5, 8'h31); wr(4'd6, 8'h12); wr(4'd7, 8'h99);
    set_eod(8'h23); pulse();
    chk(0, 8'h00, "R3"); chk(1, 8'h00, "R3"); chk(2, 8'h00, "R3");
    chk(3, 8'h00, "R3"); chk(4, 8'h01, "R3");
    chk(5, 8'h01, "R4"); chk(6, 8'h01, "R4"); chk(7, 8'h00, "R4");
  endtask

  task automatic roll_day(input logic [7:0] d, input logic [7:0] m, input logic [7:0] y,
                          input logic [7:0] ed, input logic [7:0] em, input string req);
    wr(4'd5, d); wr(4'd6, m); wr(4'd7, y); set_eod(8'h23); pulse();
    chk(5, ed, req); chk(6, em, req);
  endtask

  task automatic t_months();
    roll_day(8'h30, 8'h04, 8'h23, 8'h01, 8'h05, "R4");
    roll_day(8'h30, 8'h01, 8'h23, 8'h31, 8'h01, "R4");
    roll_day(8'h30, 8'h11, 8'h23, 8'h01, 8'h12, "R4");
    roll_day(8'h28, 8'h02, 8'h23, 8'h01, 8'h03, "R5");
    roll_day(8'h28, 8'h02, 8'h24, 8'h29, 8'h02, "R5");
    roll_day(8'h29, 8'h02, 8'h24, 8'h01, 8'h03, "R5");
    roll_day(8'h28, 8'h02, 8'h00, 8'h29, 8'h02, "R5");
    roll_day(8'h28, 8'h02, 8'h12, 8'h29, 8'h02, "R5");
    roll_day(8'h28, 8'h02, 8'h10, 8'h01, 8'h03, "R5");
  endtask

  task automatic t_twelve();
    wr(4'd3, 8'h15); wr(4'd8, 8'h01); chk(3, 8'h43, "R7"); chk(8, 8'h01, "R10");
    wr(4'd8, 8'h00); chk(3, 8'h15, "R7");
    wr(4'd3, 8'h00); wr(4'd8, 8'h01); chk(3, 8'h12, "R7");
    wr(4'd8, 8'h00); chk(3, 8'h00, "R7");
    wr(4'd3, 8'h12); wr(4'd8, 8'h01); chk(3, 8'h52, "R7");
    set_eod(8'h11); pulse(); chk(3, 8'h52, "R6");
    set_eod(8'h52); pulse(); chk(3, 8'h41, "R6");
    set_eod(8'h12); pulse(); chk(3, 8'h01, "R6");
    wr(4'd4, 8'h03); wr(4'd5, 8'h05); wr(4'd6, 8'h03);
    set_eod(8'h51); pulse();
    chk(3, 8'h12, "R6"); chk(5, 8'h06, "R6"); chk(4, 8'h04, "R6");
    wr(4'd8, 8'h00);
  endtask

  task automatic t_halt();
    wr(4'd0, 8'h10); wr(4'd1, 8'h33);
    @(negedge clk); halt = 1'b1;
    pulse(); pulse(); pulse();
    chk(0, 8'h10, "R8"); chk(1, 8'h33, "R8");
    @(negedge clk); halt = 1'b0;
    pulse(); chk(0, 8'h11, "R8");
  endtask

  task automatic t_prio();
    wr(4'd0, 8'h99); wr(4'd1, 8'h05);
    @(negedge clk); tick = 1'b1; wr_en = 1'b1; wr_sel = 4'd0; wr_data = 8'h42;
    @(negedge clk); tick = 1'b0; wr_en = 1'b0;
    chk(0, 8'h42, "R9"); chk(1, 8'h05, "R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_year_roll();
    t_months();
    t_twelve();
    t_halt();
    t_prio();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule